// File: doc/BRIEF.md
# Self-Selecting Distributed Bus Arbiter

This block arbitrates a shared bus that has no central arbiter. Every device on the bus owns one arbitration agent with a fixed identity code. The agents put their codes on a set of shared arbitration lines, one line per code bit, and combine them as a wired OR. Each agent reads the combined lines and works out for itself whether it has won. The agent with the numerically largest identity among those taking part gets the bus. It keeps the bus until it drops its request. The other agents flag that they lost and try again as soon as the bus is free.

The top level holds `N_AGENTS` agents and the wired-OR network that joins their line drivers. Agent i has identity `(ID_BASE + ID_STRIDE*i) mod 2**ID_WIDTH`. `ID_STRIDE` must be odd and `N_AGENTS` at most `2**ID_WIDTH`, so that all identities differ.

Resolution runs bit by bit from the most significant bit. At each step a contender drives its own bit. A contender that drives 0 while the line reads 1 withdraws from the round. Two modes are provided.

- **Self-select mode** always runs the full bitwise round.
- **Collision mode** first spends one probe cycle. In it, every requester drives its whole code and compares the combined lines with its own code. A mismatch raises a shared collision line. With no collision the lone requester takes the bus at once. With a collision the bitwise round follows.

The mode input is shared by all agents and is changed only while no agent is requesting. There is no data stream here: all pins are plain control and status levels.

Top module: `sbarb_top`

## Requirements
- R1: After reset, all `grant` and `lost` bits are 0 and `bus_busy` is 0.
- R2: At most one bit of `grant` is 1 in any cycle.
- R3: In self-select mode (`mode_coll`=0), the agents requesting at a clock edge E, while the bus is free, form a round. Agent i has identity (ID_BASE + ID_STRIDE*i) mod 2**ID_WIDTH. Exactly the agent with the largest identity in the round shows `grant`=1, first after edge E+ID_WIDTH, that is ID_WIDTH+1 edges counted from E. No grant shows before then.
- R4: When the winner's grant appears, every other member of the round shows `lost`=1. `lost` stays 1 while that agent keeps requesting, until the bus has been free for one edge.
- R5: The winner keeps `grant`=1 while its request is 1, and clears `grant` one edge after its request drops.
- R6: After a release, the agents still requesting form the next round, starting at the second edge after the release edge. The largest remaining identity wins, with the latency of the current mode.
- R7: A round starts only when no agent holds the bus and no arbitration is in progress. An agent that starts requesting during a round shows neither `grant` nor `lost` in that round, and takes part in the next one.
- R8: In collision mode (`mode_coll`=1), a lone requester starting a round at edge E shows `grant`=1 after edge E+1, and not before.
- R9: In collision mode, a round of two or more requesters is decided by identity priority. The largest identity shows `grant`=1 after edge E+ID_WIDTH+1, and not before.
- R10: An agent showing `lost` that drops its request shows `lost`=0 after the next edge.
- R11: `bus_busy` is 1 exactly in the cycles in which some `grant` bit is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_coll | input | 1 | 0 = self-select mode, 1 = collision mode with a probe cycle |
| req | input | N_AGENTS | Bus request of each agent |
| grant | output | N_AGENTS | Agent holds the bus |
| lost | output | N_AGENTS | Agent was beaten and waits for the bus to free |
| bus_busy | output | 1 | Some agent holds the bus |

## Verification
Every non-empty subset of the six agents is applied in both modes as one simultaneous request. Each subset is then drained winner by winner, so the order of grants must follow the descending identities. Since the identities are a permutation and not the agent indices, a design that ranks by position is told apart from one that ranks by code. Comparing subsets of one member with larger ones separates the collision-mode short path from the full bitwise round. Subsets whose codes share high bits exercise the withdrawal on the lower bits. Directed sequences add a requester arriving mid-round and a loser that gives up, which separate correct round gating from agents joining late.

// File: rtl/sbarb_pkg.sv
package sbarb_pkg;
  typedef enum logic [2:0] {
    AG_IDLE,
    AG_PROBE,
    AG_RESOLVE,
    AG_OWNER,
    AG_BEATEN
  } agent_state_t;
endpackage

// File: rtl/sbarb_wired_or.sv
module sbarb_wired_or #(
  parameter int N_AGENTS = 6,
  parameter int ID_WIDTH = 4
) (
  input  logic [N_AGENTS-1:0][ID_WIDTH-1:0] code_drv,
  input  logic [N_AGENTS-1:0]               coll_drv,
  input  logic [N_AGENTS-1:0]               active_drv,
  input  logic [N_AGENTS-1:0]               busy_drv,
  output logic [ID_WIDTH-1:0]               code_line,
  output logic                              coll_line,
  output logic                              active_line,
  output logic                              busy_line
);
  for (genvar b = 0; b < ID_WIDTH; b++) begin : g_bit
    logic [N_AGENTS-1:0] column;
    for (genvar a = 0; a < N_AGENTS; a++) begin : g_agent
      assign column[a] = code_drv[a][b];
    end
    assign code_line[b] = |column;
  end

  assign coll_line   = |coll_drv;
  assign active_line = |active_drv;
  assign busy_line   = |busy_drv;
endmodule

// File: rtl/sbarb_agent.sv
module sbarb_agent
  import sbarb_pkg::*;
#(
  parameter int                ID_WIDTH = 4,
  parameter logic [ID_WIDTH-1:0] MY_ID  = '0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_i,
  input  logic                mode_coll_i,
  input  logic [ID_WIDTH-1:0] code_line_i,
  input  logic                coll_line_i,
  input  logic                active_line_i,
  input  logic                busy_line_i,
  output logic [ID_WIDTH-1:0] code_drv_o,
  output logic                coll_drv_o,
  output logic                active_drv_o,
  output logic                busy_drv_o,
  output logic                grant_o,
  output logic                lost_o
);
  localparam int SW = (ID_WIDTH > 1) ? $clog2(ID_WIDTH) : 1;
  localparam logic [SW-1:0] TOP_STEP = SW'(ID_WIDTH - 1);

  agent_state_t state, state_n;
  logic [SW-1:0] step, step_n;

  logic bus_free;
  logic my_bit, line_bit;
  agent_state_t start_state;

  assign bus_free    = !busy_line_i && !active_line_i;
  assign my_bit      = MY_ID[step];
  assign line_bit    = code_line_i[step];
  assign start_state = mode_coll_i ? AG_PROBE : AG_RESOLVE;

  always_comb begin
    state_n = state;
    step_n  = step;
    case (state)
      AG_IDLE: begin
        if (req_i && bus_free) begin
          state_n = start_state;
          step_n  = TOP_STEP;
        end
      end
      AG_PROBE: begin
        if (!req_i) state_n = AG_IDLE;
        else if (!coll_line_i) state_n = AG_OWNER;
        else begin
          state_n = AG_RESOLVE;
          step_n  = TOP_STEP;
        end
      end
      AG_RESOLVE: begin
        if (!req_i) state_n = AG_IDLE;
        else if (!my_bit && line_bit) state_n = AG_BEATEN;
        else if (step == '0) state_n = AG_OWNER;
        else step_n = step - 1'b1;
      end
      AG_OWNER: begin
        if (!req_i) state_n = AG_IDLE;
      end
      AG_BEATEN: begin
        if (!req_i) state_n = AG_IDLE;
        else if (bus_free) begin
          state_n = start_state;
          step_n  = TOP_STEP;
        end
      end
      default: state_n = AG_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= AG_IDLE;
      step  <= '0;
    end else begin
      state <= state_n;
      step  <= step_n;
    end
  end

  always_comb begin
    code_drv_o = '0;
    if (state == AG_PROBE) code_drv_o = MY_ID;
    else if (state == AG_RESOLVE) code_drv_o = MY_ID & (ID_WIDTH'(1) << step);
  end

  assign coll_drv_o   = (state == AG_PROBE) && (code_line_i != MY_ID);
  assign active_drv_o = (state == AG_PROBE) || (state == AG_RESOLVE);
  assign busy_drv_o   = (state == AG_OWNER);
  assign grant_o      = (state == AG_OWNER);
  assign lost_o       = (state == AG_BEATEN);

  // R4: a contender that reads 1 over its own 0 leaves the round
  p_withdraw_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == AG_RESOLVE && req_i && !my_bit && line_bit) |=> lost_o);

  // R7: no round begins while the bus is held or a round runs
  p_gated_start_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!grant_o && !active_drv_o && !bus_free) |=> !active_drv_o);

  // R5: owner keeps the bus while requesting
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && req_i) |=> grant_o);

  // R5: owner releases one edge after request drops
  p_release_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_o && !req_i) |=> !grant_o);

  // R8: a probe with no collision gives the bus next edge
  p_probe_solo_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == AG_PROBE && req_i && !coll_line_i) |=> grant_o);

  // R10: a beaten agent dropping its request clears lost
  p_lost_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (lost_o && !req_i) |=> !lost_o);
endmodule

// File: rtl/sbarb_top.sv
module sbarb_top #(
  parameter int N_AGENTS  = 6,
  parameter int ID_WIDTH  = 4,
  parameter int ID_BASE   = 3,
  parameter int ID_STRIDE = 5
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mode_coll,
  input  logic [N_AGENTS-1:0] req,
  output logic [N_AGENTS-1:0] grant,
  output logic [N_AGENTS-1:0] lost,
  output logic                bus_busy
);
  localparam int ID_SPACE = 1 << ID_WIDTH;

  logic [N_AGENTS-1:0][ID_WIDTH-1:0] code_drv;
  logic [N_AGENTS-1:0]               coll_drv, active_drv, busy_drv;
  logic [ID_WIDTH-1:0]               code_line;
  logic                              coll_line, active_line, busy_line;

  for (genvar g = 0; g < N_AGENTS; g++) begin : g_agent
    localparam logic [ID_WIDTH-1:0] AG_ID = ID_WIDTH'((ID_BASE + ID_STRIDE * g) % ID_SPACE);
    sbarb_agent #(
      .ID_WIDTH (ID_WIDTH),
      .MY_ID    (AG_ID)
    ) u_agent (
      .clk           (clk),
      .rst_n         (rst_n),
      .req_i         (req[g]),
      .mode_coll_i   (mode_coll),
      .code_line_i   (code_line),
      .coll_line_i   (coll_line),
      .active_line_i (active_line),
      .busy_line_i   (busy_line),
      .code_drv_o    (code_drv[g]),
      .coll_drv_o    (coll_drv[g]),
      .active_drv_o  (active_drv[g]),
      .busy_drv_o    (busy_drv[g]),
      .grant_o       (grant[g]),
      .lost_o        (lost[g])
    );
  end

  sbarb_wired_or #(
    .N_AGENTS (N_AGENTS),
    .ID_WIDTH (ID_WIDTH)
  ) u_lines (
    .code_drv    (code_drv),
    .coll_drv    (coll_drv),
    .active_drv  (active_drv),
    .busy_drv    (busy_drv),
    .code_line   (code_line),
    .coll_line   (coll_line),
    .active_line (active_line),
    .busy_line   (busy_line)
  );

  assign bus_busy = busy_line;

  // R2: a single owner at most
  p_one_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant));

  // R4: nobody owns and is beaten at once across the agents
  p_grant_lost_apart_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (grant & lost) == '0);
endmodule

// File: tb/sim_sbarb_top.sv
`timescale 1ns/1ps
module sim_sbarb_top;
  localparam int N = 6;
  localparam int W = 4;
  localparam int BASE = 3;
  localparam int STRIDE = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_coll = 1'b0;
  logic [N-1:0] req = '0;
  logic [N-1:0] grant, lost;
  logic bus_busy;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sbarb_top #(.N_AGENTS(N), .ID_WIDTH(W), .ID_BASE(BASE), .ID_STRIDE(STRIDE)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_coll(mode_coll), .req(req),
    .grant(grant), .lost(lost), .bus_busy(bus_busy)
  );

  function automatic int ident(int i);
    return (BASE + STRIDE * i) % (1 << W);
  endfunction

  function automatic int pick(logic [N-1:0] s);
    int best = -1;
    for (int i = 0; i < N; i++)
      if (s[i] && (best < 0 || ident(i) > ident(best))) best = i;
    return best;
  endfunction

  function automatic int latency(logic [N-1:0] s, logic m);
    if (!m) return W + 1;
    if ($countones(s) == 1) return 2;
    return W + 2;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic edges(int n);
    repeat (n) @(negedge clk);
  endtask

  // inputs have just changed at a negedge; the round starts at the next edge
  task automatic expect_round(logic [N-1:0] s);
    int d = latency(s, mode_coll);
    int w = pick(s);
    logic [N-1:0] wbit = N'(1) << w;
    edges(d - 1);
    chk(grant == '0, mode_coll ? ($countones(s) == 1 ? "R8 early grant" : "R9 early grant")
                               : "R3 early grant", int'(grant), 0);
    edges(1);
    chk(grant == wbit, mode_coll ? ($countones(s) == 1 ? "R8 winner" : "R9 winner")
                                 : "R3 winner", int'(grant), int'(wbit));
    chk(lost == (s & ~wbit), "R4 losers flagged", int'(lost), int'(s & ~wbit));
    chk(bus_busy == 1'b1, "R11 busy with grant", int'(bus_busy), 1);
  endtask

  initial begin
    #(8 * 200000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [N-1:0] cur;
    int w;
    edges(3);
    chk(grant == '0, "R1 grant at reset", int'(grant), 0);
    chk(lost == '0, "R1 lost at reset", int'(lost), 0);
    chk(bus_busy == 1'b0, "R1 busy at reset", int'(bus_busy), 0);
    rst_n = 1'b1;
    edges(2);

    // sweep every subset in both modes, draining winner by winner (R6)
    for (int m = 0; m < 2; m++) begin
      mode_coll = m[0];
      for (int s = 1; s < (1 << N); s++) begin
        cur = N'(s);
        req = cur;
        while (cur != '0) begin
          expect_round(cur);
          w = pick(cur);
          edges(2);
          chk(grant == (N'(1) << w), "R5 hold", int'(grant), int'(N'(1) << w));
          req[w] = 1'b0;
          cur[w] = 1'b0;
          edges(1);
          chk(grant == '0, "R5 release", int'(grant), 0);
          chk(bus_busy == 1'b0, "R11 busy clears", int'(bus_busy), 0);
          chk(lost == cur, "R4 lost held until free", int'(lost), int'(cur));
          // remaining requesters start at the next edge: R6
        end
        edges(1);
        chk(grant == '0 && lost == '0, "R6 idle after drain", int'(grant | lost), 0);
      end
    end

    // R7: a late, higher requester waits for the next round
    mode_coll = 1'b0;
    req = N'(1) << 3;
    edges(2);
    req[2] = 1'b1;
    edges(W - 1);
    chk(grant == (N'(1) << 3), "R7 early requester keeps round", int'(grant), 8);
    chk(lost[2] == 1'b0, "R7 late requester not lost", int'(lost[2]), 0);
    edges(2);
    chk(grant[2] == 1'b0, "R7 late requester not granted", int'(grant[2]), 0);
    req[3] = 1'b0;
    edges(1);
    edges(W);
    chk(grant == '0, "R7 next round not yet done", int'(grant), 0);
    edges(1);
    chk(grant == (N'(1) << 2), "R7 late requester wins next round", int'(grant), 4);
    req = '0;
    edges(2);

    // R10: a beaten agent giving up clears lost
    req = N'(5);
    edges(W + 1);
    chk(grant == (N'(1) << 2), "R10 setup winner", int'(grant), 4);
    chk(lost == N'(1), "R10 setup loser", int'(lost), 1);
    req[0] = 1'b0;
    edges(1);
    chk(lost == '0, "R10 lost cleared", int'(lost), 0);
    chk(grant == (N'(1) << 2), "R10 winner unaffected", int'(grant), 4);
    req = '0;
    edges(2);
    chk(grant == '0 && bus_busy == 1'b0, "R2 final idle", int'(grant), 0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule